// File: doc/BRIEF.md
# Event-Select Counter Bank

This block holds a small bank of independent event counters for on-chip performance measurement. A vector of single-cycle event pulses enters the block, one bit per event code. Each counter owns a selection register that names one bit of that vector. While its selection is valid, the counter adds one in every cycle in which the chosen bit is high.

Software drives the bank through a plain register port. A write to a selection register both chooses the event and restarts the counter from zero. The reserved code 0xFF disarms the counter. A write of zero to a count register clears the accumulated value and leaves the selection as it was. Any other value written to a count register is dropped. Reads return either the stored code or the present count, one cycle after the request.

Counts are CNT_W bits wide, 64 by default, and wrap on overflow. The number of counters is set in the shared package. The number of event inputs is a parameter of the top module.

Top module: `perf_mon_bank`

## Requirements
- R1: After reset, every selection register reads 0xFF, every count reads zero, and `rdValid` stays low while `rst` is high.
- R2: A write with `regAddr[2]=0` stores `regWdata[7:0]` as the code of counter `regAddr[1:0]`. The count becomes zero at that edge and counting starts from the following cycle.
- R3: An armed counter adds exactly one in each cycle in which `events[code]` is high, and holds in every other cycle.
- R4: The code 0xFF leaves a counter stopped: its count stays constant whatever the events do.
- R5: A code at or above NUM_EVT stops the counter in the same way as 0xFF, and the stored code still reads back unchanged.
- R6: A write of zero with `regAddr[2]=1` clears that counter. It keeps its code and goes on counting from zero.
- R7: A non-zero write with `regAddr[2]=1` does not change the stored count. The counter keeps counting its selected event in that cycle as usual.
- R8: When a clear and a selected event pulse fall in the same cycle, the clear wins and the count is zero afterwards.
- R9: A write that targets one counter leaves the code and the count of every other counter untouched.
- R10: A read (`regValid=1`, `regWrite=0`) raises `rdValid` for exactly one cycle after the request edge. `rdData` then carries the value the addressed register held before that edge, with a code zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| events | input | NUM_EVT | Per-cycle event pulses, indexed by event code |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 3 | Bit 2: 0 = selection, 1 = count; bits 1:0 = counter index |
| regWdata | input | CNT_W | Write data; selection writes use bits 7:0 |
| rdValid | output | 1 | Read data valid, one cycle after a read request |
| rdData | output | CNT_W | Read data |

## Verification
A bad stored code or a bad armed state shows up as a count that drifts away from the number of selected pulses. It becomes visible on the next read of that counter, and the bench reads after each phase of stimulus. A clear or an arm that fails to zero the count, or a write that lands on the wrong index, shows up in the read that follows it. That read also checks that the neighbouring counters kept their values. A broken read path gives a wrong value or a missing `rdValid` in the very next cycle, and the scoreboard notices both an unmatched response and a response left in its queue.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int CNT_NUM = 4;
  localparam int CODE_W  = 8;
  localparam int IDX_W   = $clog2(CNT_NUM);
  localparam logic [CODE_W-1:0] CODE_OFF = '1;

  typedef struct packed {
    logic [CNT_NUM-1:0] selWr;
    logic [CNT_NUM-1:0] cntClr;
    logic               rdReq;
    logic               rdCnt;
    logic [IDX_W-1:0]   rdIdx;
    logic [CODE_W-1:0]  code;
  } pm_strobe_t;
endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             regValid,
  input  logic             regWrite,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output pm_strobe_t       strb
);
  logic             isCntSpace;
  logic [IDX_W-1:0] idx;
  logic             wrZero;

  assign isCntSpace = regAddr[2];
  assign idx        = regAddr[IDX_W-1:0];
  assign wrZero     = (regWdata == '0);

  always_comb begin
    strb        = '0;
    strb.code   = regWdata[CODE_W-1:0];
    strb.rdCnt  = isCntSpace;
    strb.rdIdx  = idx;
    strb.rdReq  = regValid && !regWrite;
    for (int i = 0; i < CNT_NUM; i++) begin
      if (regValid && regWrite && (idx == IDX_W'(i))) begin
        strb.selWr[i]  = !isCntSpace;
        strb.cntClr[i] = isCntSpace && wrZero;
      end
    end
  end
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int NUM_EVT = 32,
  parameter int CNT_W   = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] events,
  input  pm_strobe_t         strb,
  output logic               rdValid,
  output logic [CNT_W-1:0]   rdData
);
  localparam int EIDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [CODE_W-1:0] codeQ [CNT_NUM];
  logic [CNT_W-1:0]  cntQ  [CNT_NUM];
  logic [CNT_NUM-1:0] armed;
  logic [CNT_NUM-1:0] hit;

  always_comb begin
    for (int i = 0; i < CNT_NUM; i++) begin
      armed[i] = (int'(codeQ[i]) < NUM_EVT);
      hit[i]   = armed[i] && events[codeQ[i][EIDX_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CNT_NUM; i++) begin
        codeQ[i] <= CODE_OFF;
        cntQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < CNT_NUM; i++) begin
        if (strb.selWr[i]) begin
          codeQ[i] <= strb.code;
          cntQ[i]  <= '0;
        end else if (strb.cntClr[i]) begin
          cntQ[i]  <= '0;
        end else if (hit[i]) begin
          cntQ[i]  <= cntQ[i] + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdReq;
      if (strb.rdReq) begin
        rdData <= strb.rdCnt ? cntQ[strb.rdIdx] : CNT_W'(codeQ[strb.rdIdx]);
      end
    end
  end

  // R10: a read request is answered in the next cycle
  a_r10_read_answer: assert property (@(posedge clk) disable iff (rst)
    strb.rdReq |=> rdValid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !strb.rdReq |=> !rdValid);

  for (genvar g = 0; g < CNT_NUM; g++) begin : g_chk
    // R2: arming restarts from zero
    a_r2_arm_zero: assert property (@(posedge clk) disable iff (rst)
      strb.selWr[g] |=> (cntQ[g] == '0));
    // R8: clear beats a coincident pulse
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
      strb.cntClr[g] |=> (cntQ[g] == '0));
    // R4 / R5: a stopped counter holds
    a_r4_stopped_hold: assert property (@(posedge clk) disable iff (rst)
      (!armed[g] && !strb.selWr[g] && !strb.cntClr[g]) |=> $stable(cntQ[g]));
    // R3: at most one step per cycle
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
      (!strb.selWr[g] && !strb.cntClr[g]) |=>
        (cntQ[g] == $past(cntQ[g]) || cntQ[g] == $past(cntQ[g]) + CNT_W'(1)));
  end
endmodule

// File: rtl/perf_mon_bank.sv
module perf_mon_bank
  import pm_pkg::*;
#(
  parameter int NUM_EVT = 32,
  parameter int CNT_W   = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] events,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [2:0]         regAddr,
  input  logic [CNT_W-1:0]   regWdata,
  output logic               rdValid,
  output logic [CNT_W-1:0]   rdData
);
  pm_strobe_t strb;

  pm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strb     (strb)
  );

  pm_datapath #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .events  (events),
    .strb    (strb),
    .rdValid (rdValid),
    .rdData  (rdData)
  );
endmodule

// File: tb/sim_perf_mon_bank.sv
module sim_perf_mon_bank;
  localparam int NE = 32;
  localparam int CW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] events;
  logic          regValid = 1'b0, regWrite = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [CW-1:0] regWdata = '0;
  logic          rdValid;
  logic [CW-1:0] rdData;

  logic          freeRun = 1'b0;
  logic [31:0]   lfsr = 32'h1234_5678;
  logic [NE-1:0] manualVec = '0;
  assign events = freeRun ? lfsr[NE-1:0] : manualVec;

  int total = 0, bad = 0;
  bit done = 0;

  logic [CW-1:0] expQ[$];
  string         tagQ[$];
  logic [7:0]    mCode [4];
  logic [CW-1:0] mCnt  [4];

  always #2.5 clk = ~clk;

  perf_mon_bank #(.NUM_EVT(NE), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .events(events), .regValid(regValid),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .rdValid(rdValid), .rdData(rdData));

  always @(negedge clk) if (freeRun) lfsr <= {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};

  // reference model from the requirements; pushes expected read data
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin mCode[i] = 8'hFF; mCnt[i] = '0; end
    end else begin
      if (regValid && !regWrite)
        expQ.push_back(regAddr[2] ? mCnt[regAddr[1:0]] : CW'(mCode[regAddr[1:0]]));
      for (int i = 0; i < 4; i++) begin
        if (regValid && regWrite && regAddr[1:0] == i[1:0] && !regAddr[2]) begin
          mCode[i] = regWdata[7:0]; mCnt[i] = '0;
        end else if (regValid && regWrite && regAddr[1:0] == i[1:0] && regWdata == '0) begin
          mCnt[i] = '0;
        end else if (mCode[i] < NE && events[mCode[i][4:0]]) begin
          mCnt[i] = mCnt[i] + 1;
        end
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && rdValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++; $display("FAIL R10 unexpected response actual=%h expected=none", rdData);
      end else begin
        logic [CW-1:0] e; string t;
        e = expQ.pop_front(); t = tagQ.pop_front();
        if (rdData !== e) begin
          bad++; $display("FAIL %s actual=%h expected=%h", t, rdData, e);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(bit wr, logic [2:0] a, logic [CW-1:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = wr; regAddr = a; regWdata = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, string tag);
    tagQ.push_back(tag);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    @(negedge clk);
    regValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (rdValid !== 1'b0) begin bad++; $display("FAIL R1 rdValid in reset actual=%b expected=0", rdValid); end
    rst = 1'b0;
    for (int i = 0; i < 8; i++) rd(3'(i), "R1");
    access(1, 3'd0, 64'd3);            // R2 arm counter 0 on event 3
    access(1, 3'd1, 64'd5);
    access(1, 3'd2, 64'd40);           // R5 out of range code
    freeRun = 1'b1;
    idle(20);
    rd(3'd2, "R5"); rd(3'd6, "R5");
    rd(3'd4, "R3"); rd(3'd5, "R3");
    rd(3'd7, "R4"); rd(3'd0, "R10");
    access(1, 3'd4, 64'h123);          // R7 rejected non-zero write
    rd(3'd4, "R7");
    freeRun = 1'b0; manualVec = '1;
    access(1, 3'd5, 64'd0);            // R8 clear with pulse present
    rd(3'd5, "R8");
    idle(5);
    rd(3'd5, "R6"); rd(3'd1, "R6");
    manualVec = 32'h0000_0020;         // only event 5
    rd(3'd6, "R9");
    access(1, 3'd0, 64'd7);            // reprogram counter 0
    rd(3'd5, "R9"); rd(3'd4, "R2"); rd(3'd0, "R10");
    rd(3'd1, "R9");
    access(1, 3'd1, 64'hFF);           // R4 disarm
    freeRun = 1'b1;
    idle(10);
    rd(3'd5, "R4"); rd(3'd1, "R4");
    freeRun = 1'b0;
    idle(4);
    total++;
    if (expQ.size() != 0) begin bad++; $display("FAIL R10 missing responses actual=%0d expected=0", expQ.size()); end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule